// File: doc/BRIEF.md
# Preamble-Synced Serial Word Receiver

This block turns a serial bit stream read from a rotating storage track into 32-bit words. A start pulse carries a begin address. The block then hunts for a fixed 32-bit preamble pattern. The pattern counts only when its final bit arrives while the current track address equals the begin address. If a full revolution passes without a match, the hunt is abandoned and a sync-error status is raised.

Once the block is locked, every bit marked by the bit-enable strobe is shifted, MSB first, into a serial-to-parallel register. A running parity check covers each 16-bit half of the word as its bits arrive. Each completed word is presented for one cycle with a valid strobe and a parity-error flag, so a downstream buffer can capture it. Reading continues until the next start pulse.

Top module: `rx_preamble_word_rx`

## Requirements
- R1: While reset is asserted and right after it, `word_o` is zero and `word_vld_o`, `par_err_o` and `sync_err_o` are low.
- R2: Without a start pulse, or after a sync error, the bit stream produces no `word_vld_o` pulse, even if it carries the preamble at the begin address.
- R3: Lock happens only in a bit-enable cycle where two things hold. First, at least 32 bits, counting the current one, have been shifted since the start pulse. Second, the last 32 bits, oldest first, equal the `PREAMBLE` parameter and `drum_addr_i` equals the latched begin address. A preamble that ends at any other address does not lock.
- R4: During the hunt, the second cycle with `index_i` high that does not also lock sets `sync_err_o` from the next cycle. The flag stays high until a start pulse, and no words follow it.
- R5: A single index pulse during the hunt neither raises `sync_err_o` nor stops the hunt.
- R6: After lock, each group of 32 bit-enable cycles yields one word. Bit 31 of the word is the first bit received. `word_vld_o` is high for exactly the cycle after the clock edge that samples the 32nd bit. Cycles with `bit_en_i` low shift nothing.
- R7: Bits 31:16 and 15:0 each form an odd-parity group, so the XOR of the 16 bits must be 1. `par_err_o` is high together with `word_vld_o` when either half fails, is low for a word whose halves both pass, and is low whenever `word_vld_o` is low.
- R8: A start pulse in any state clears `sync_err_o`, discards any partly assembled word and begins a new hunt from an empty pattern window.
- R9: Once locked, the block keeps producing words back to back for as long as bits arrive, with no further preamble needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches the begin address and starts the hunt |
| begin_addr_i | input | ADDR_W | Track address where the preamble must end |
| bit_en_i | input | 1 | Bit strobe; `bit_i` is valid in this cycle |
| bit_i | input | 1 | Serial data bit |
| drum_addr_i | input | ADDR_W | Current track address under the head |
| index_i | input | 1 | One-cycle pulse, once per revolution |
| word_o | output | WORD_W | Last completed word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| par_err_o | output | 1 | Parity failure for the word on `word_o` |
| sync_err_o | output | 1 | Preamble not found within one revolution |

## Verification
The hardest situation to reach is a false lock. One case is a window that matches the pattern at the wrong address. Another is a window that only seems to match because the register was cleared at start before it had filled. The bench sends the first 31 preamble bits at a foreign address and only the last bit at the begin address. It also picks a pattern whose MSB is zero, so a 31-bit partial send after start would match without the fill guard. A second hard case is the timeout racing a lock. The bench places one index pulse before a successful preamble and two index pulses before a preamble that must then be ignored.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HUNT = 2'd1,
      ST_READ = 2'd2
   } rx_state_e;
endpackage

// File: rtl/rx_preamble_hunt.sv
module rx_preamble_hunt #(
   parameter int unsigned           WORD_W   = 32,
   parameter logic [WORD_W-1:0]     PREAMBLE = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic active_i,
   input  logic bit_en_i,
   input  logic bit_i,
   input  logic addr_hit_i,
   input  logic index_i,
   output logic found_o,
   output logic timeout_o
);
   localparam int unsigned FILL_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] window_q;
   logic [WORD_W-1:0] window_nx;
   logic [FILL_W-1:0] fill_q;
   logic              rev_seen_q;
   logic              full_nx;

   assign window_nx = {window_q[WORD_W-2:0], bit_i};
   assign full_nx   = (fill_q >= FILL_W'(WORD_W - 1));
   assign found_o   = active_i && bit_en_i && addr_hit_i && full_nx && (window_nx == PREAMBLE);
   assign timeout_o = active_i && index_i && rev_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         window_q   <= '0;
         fill_q     <= '0;
         rev_seen_q <= 1'b0;
      end else if (clear_i) begin
         window_q   <= '0;
         fill_q     <= '0;
         rev_seen_q <= 1'b0;
      end else if (active_i) begin
         if (bit_en_i) begin
            window_q <= window_nx;
            if (fill_q != FILL_W'(WORD_W)) fill_q <= fill_q + 1'b1;
         end
         if (index_i) rev_seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rx_word_deser.sv
module rx_word_deser #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              active_i,
   input  logic              bit_en_i,
   input  logic              bit_i,
   output logic              done_o,
   output logic [WORD_W-1:0] word_nx_o
);
   localparam int unsigned CNT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] shift_q;
   logic [CNT_W-1:0]  cnt_q;

   assign word_nx_o = {shift_q[WORD_W-2:0], bit_i};
   assign done_o    = active_i && bit_en_i && (cnt_q == CNT_W'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         shift_q <= '0;
         cnt_q   <= '0;
      end else if (active_i && bit_en_i) begin
         shift_q <= word_nx_o;
         cnt_q   <= done_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk #(
   parameter int unsigned GROUP_W = 16,
   parameter bit          ODD     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic active_i,
   input  logic bit_en_i,
   input  logic bit_i,
   input  logic word_end_i,
   output logic err_o
);
   localparam int unsigned G_W = $clog2(GROUP_W);

   logic [G_W-1:0] gcnt_q;
   logic           acc_q;
   logic           sticky_q;
   logic           acc_nx;
   logic           grp_end;
   logic           grp_bad;

   assign acc_nx  = acc_q ^ bit_i;
   assign grp_end = active_i && bit_en_i && (gcnt_q == G_W'(GROUP_W - 1));

   generate
      if (ODD) begin : g_odd
         assign grp_bad = grp_end && !acc_nx;
      end else begin : g_even
         assign grp_bad = grp_end && acc_nx;
      end
   endgenerate

   assign err_o = sticky_q | grp_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt_q   <= '0;
         acc_q    <= 1'b0;
         sticky_q <= 1'b0;
      end else if (clear_i) begin
         gcnt_q   <= '0;
         acc_q    <= 1'b0;
         sticky_q <= 1'b0;
      end else if (active_i && bit_en_i) begin
         if (grp_end) begin
            gcnt_q <= '0;
            acc_q  <= 1'b0;
         end else begin
            gcnt_q <= gcnt_q + 1'b1;
            acc_q  <= acc_nx;
         end
         if (word_end_i)   sticky_q <= 1'b0;
         else if (grp_bad) sticky_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rx_preamble_word_rx.sv
module rx_preamble_word_rx #(
   parameter int unsigned        WORD_W   = 32,
   parameter int unsigned        GROUP_W  = 16,
   parameter int unsigned        ADDR_W   = 10,
   parameter bit                 ODD      = 1'b1,
   parameter logic [WORD_W-1:0]  PREAMBLE = 32'h5A3C_96E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] begin_addr_i,
   input  logic              bit_en_i,
   input  logic              bit_i,
   input  logic [ADDR_W-1:0] drum_addr_i,
   input  logic              index_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              par_err_o,
   output logic              sync_err_o
);
   import rxw_pkg::*;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (GROUP_W < 2 || (WORD_W % GROUP_W) != 0) begin : g_bad_group
         $error("GROUP_W must be at least 2 and divide WORD_W");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   rx_state_e         state_q;
   logic [ADDR_W-1:0] begin_q;
   logic              hunt_act;
   logic              read_act;
   logic              found;
   logic              timeout;
   logic              done;
   logic              perr;
   logic [WORD_W-1:0] word_nx;

   assign hunt_act = (state_q == ST_HUNT) && !start_i;
   assign read_act = (state_q == ST_READ) && !start_i;

   rx_preamble_hunt #(.WORD_W(WORD_W), .PREAMBLE(PREAMBLE)) u_hunt (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .active_i(hunt_act),
      .bit_en_i(bit_en_i), .bit_i(bit_i), .addr_hit_i(drum_addr_i == begin_q),
      .index_i(index_i), .found_o(found), .timeout_o(timeout)
   );

   rx_word_deser #(.WORD_W(WORD_W)) u_deser (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .active_i(read_act),
      .bit_en_i(bit_en_i), .bit_i(bit_i), .done_o(done), .word_nx_o(word_nx)
   );

   rx_parity_chk #(.GROUP_W(GROUP_W), .ODD(ODD)) u_par (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .active_i(read_act),
      .bit_en_i(bit_en_i), .bit_i(bit_i), .word_end_i(done), .err_o(perr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         begin_q    <= '0;
         sync_err_o <= 1'b0;
      end else if (start_i) begin
         state_q    <= ST_HUNT;
         begin_q    <= begin_addr_i;
         sync_err_o <= 1'b0;
      end else if (state_q == ST_HUNT) begin
         if (found) begin
            state_q <= ST_READ;
         end else if (timeout) begin
            state_q    <= ST_IDLE;
            sync_err_o <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o     <= '0;
         word_vld_o <= 1'b0;
         par_err_o  <= 1'b0;
      end else begin
         word_vld_o <= done;
         par_err_o  <= done && perr;
         if (done) word_o <= word_nx;
      end
   end
endmodule

// File: rtl/rx_preamble_word_rx_chk.sv
module rx_preamble_word_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic bit_en_i,
   input logic index_i,
   input logic word_vld_o,
   input logic par_err_o,
   input logic sync_err_o
);
   assert_vld_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> $past(bit_en_i));
   assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);
   assert_perr_with_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
      par_err_o |-> word_vld_o);
   assert_sync_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err_o && !start_i) |=> sync_err_o);
   assert_sync_from_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_err_o) |-> $past(index_i));
   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!sync_err_o && !word_vld_o));
   assert_quiet_on_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_o |-> !word_vld_o);
endmodule

bind rx_preamble_word_rx rx_preamble_word_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_en_i(bit_en_i),
   .index_i(index_i), .word_vld_o(word_vld_o), .par_err_o(par_err_o),
   .sync_err_o(sync_err_o)
);

// File: tb/sim_rx_preamble_word_rx.sv
module sim_rx_preamble_word_rx;
   localparam int unsigned AW = 10;
   localparam logic [31:0] PRE = 32'h5A3C_96E1;
   localparam logic [AW-1:0] A_OK = 10'h155;
   localparam logic [AW-1:0] A_NO = 10'h0AA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] baddr = A_OK;
   logic bit_en = 1'b0;
   logic bit_d = 1'b0;
   logic [AW-1:0] daddr = '0;
   logic idx = 1'b0;
   logic [31:0] word;
   logic vld, perr, serr;

   int checks = 0;
   int errors = 0;
   int vld_cnt = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   rx_preamble_word_rx #(.ADDR_W(AW), .PREAMBLE(PRE)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .begin_addr_i(baddr),
      .bit_en_i(bit_en), .bit_i(bit_d), .drum_addr_i(daddr), .index_i(idx),
      .word_o(word), .word_vld_o(vld), .par_err_o(perr), .sync_err_o(serr)
   );

   always @(negedge clk) if (vld) vld_cnt++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic b, input logic [AW-1:0] a,
                       input logic ix, input logic st);
      @(negedge clk);
      bit_en = en; bit_d = b; daddr = a; idx = ix; start = st;
      @(posedge clk); #1;
   endtask

   function automatic logic [31:0] make_word(input logic [29:0] d);
      return {~^d[29:15], d[29:15], ~^d[14:0], d[14:0]};
   endfunction

   function automatic logic exp_perr(input logic [31:0] w);
      return (~^w[31:16]) | (~^w[15:0]);
   endfunction

   task automatic do_start;
      step(1'b0, 1'b0, A_NO, 1'b0, 1'b1);
      step(1'b0, 1'b0, A_NO, 1'b0, 1'b0);
   endtask

   // nbits MSB-first bits of v; only the final bit at a_last
   task automatic send_raw(input logic [31:0] v, input int nbits, input logic [AW-1:0] a_last);
      for (int i = nbits - 1; i >= 0; i--) begin
         if ($urandom % 4 == 0) step(1'b0, 1'b0, A_NO, 1'b0, 1'b0);
         step(1'b1, v[i], (i == 0) ? a_last : A_NO, 1'b0, 1'b0);
      end
   endtask

   task automatic send_word(input logic [31:0] w, input string req);
      int early = 0;
      for (int i = 31; i >= 0; i--) begin
         if ($urandom % 4 == 0) begin
            step(1'b0, 1'b0, A_NO, 1'b0, 1'b0);
            if (vld) early++;
         end
         step(1'b1, w[i], A_NO, 1'b0, 1'b0);
         if (i > 0 && vld) early++;
      end
      chk(early == 0, req, early, 0);
      chk(vld === 1'b1, req, vld, 1);
      chk(word === w, req, word, w);
      chk(perr === exp_perr(w), "R7", perr, exp_perr(w));
      step(1'b0, 1'b0, A_NO, 1'b0, 1'b0);
      chk(vld === 1'b0 && perr === 1'b0, "R6", {vld, perr}, 0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      logic [31:0] w;
      void'($urandom(32'd20240611));
      // R1
      repeat (3) @(posedge clk);
      #1;
      chk(word === '0 && vld === 1'b0 && perr === 1'b0 && serr === 1'b0, "R1",
          {word[28:0], vld, perr, serr}, 0);
      @(negedge clk); rst_n = 1'b1;
      step(1'b0, 1'b0, A_NO, 1'b0, 1'b0);
      chk(word === '0 && vld === 1'b0 && serr === 1'b0, "R1", {word[30:0], serr}, 0);

      // R2: no start, preamble at begin address
      base = vld_cnt;
      send_raw(PRE, 32, A_OK);
      send_raw(make_word(30'h1234567), 32, A_NO);
      chk(vld_cnt == base, "R2", vld_cnt - base, 0);

      // R3: preamble ending at a foreign address does not lock
      do_start();
      base = vld_cnt;
      send_raw(PRE, 32, A_NO);
      send_raw(make_word(30'h2AAAAAA), 32, A_NO);
      send_raw(make_word(30'h0F0F0F0), 32, A_NO);
      chk(vld_cnt == base, "R3 wrong address", vld_cnt - base, 0);

      // R3: 31-bit partial preamble right after start must not lock
      do_start();
      send_raw(PRE, 31, A_OK);
      send_raw(make_word(30'h3333333), 32, A_NO);
      send_raw(make_word(30'h1111111), 32, A_NO);
      chk(vld_cnt == base, "R3 fill", vld_cnt - base, 0);

      // R3/R6/R9: proper lock then back-to-back words
      send_raw(PRE, 32, A_OK);
      for (int k = 0; k < 4; k++) send_word(make_word(30'($urandom)), "R9");
      // R7 directed: high-half and low-half faults
      w = make_word(30'h155AA33); w[20] = ~w[20];
      send_word(w, "R7 high half");
      w = make_word(30'h0C0FFEE); w[3] = ~w[3];
      send_word(w, "R7 low half");
      w = make_word(30'h0C0FFEE); w[31] = ~w[31]; w[15] = ~w[15];
      send_word(w, "R7 both halves");
      send_word(make_word(30'h3FFFFFF), "R7 clean after fault");
      // random mix
      for (int k = 0; k < 20; k++) begin
         w = make_word(30'($urandom));
         if ($urandom % 3 == 0) w[$urandom % 32] ^= 1'b1;
         send_word(w, "R6");
      end

      // R8: start mid-word discards partial word
      send_raw(32'h0000_03A5, 10, A_NO);
      do_start();
      send_raw(PRE, 32, A_OK);
      send_word(make_word(30'h2468ACE), "R8");

      // R5: single index keeps hunt alive
      do_start();
      step(1'b0, 1'b0, A_NO, 1'b1, 1'b0);
      step(1'b0, 1'b0, A_NO, 1'b0, 1'b0);
      chk(serr === 1'b0, "R5", serr, 0);
      send_raw(PRE, 32, A_OK);
      send_word(make_word(30'h1357BDF), "R5");

      // R4: second index pulse ends the hunt
      do_start();
      step(1'b0, 1'b0, A_NO, 1'b1, 1'b0);
      send_raw(make_word(30'h0ABCDEF), 32, A_NO);
      chk(serr === 1'b0, "R4 before second index", serr, 0);
      step(1'b0, 1'b0, A_NO, 1'b1, 1'b0);
      chk(serr === 1'b1, "R4", serr, 1);
      base = vld_cnt;
      send_raw(PRE, 32, A_OK);
      send_raw(make_word(30'h1234321), 32, A_NO);
      chk(vld_cnt == base, "R4 no words", vld_cnt - base, 0);
      chk(serr === 1'b1, "R4 sticky", serr, 1);

      // R8: start clears the error and a new hunt succeeds
      do_start();
      chk(serr === 1'b0, "R8 clear", serr, 0);
      send_raw(PRE, 32, A_OK);
      send_word(make_word(30'h0FEDCBA), "R8 relock");

      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule